// File: doc/BRIEF.md
# Synthesizer Configuration Word Latch

This block keeps the configuration word for a frequency synthesizer. The word has three fields: a 7-bit loop divider value, a 2-bit output divider code and a 3-bit test selector. Software or a board controller can write the word over either of two paths. The first is a three-wire serial path, made of a serial clock, a data line and an active-high load strobe. The second is a parallel path, made of divider pins and an active-low load strobe. The test selector can be written only through the serial path.

All the serial and parallel inputs are asynchronous to the block clock `clk`, so each one passes through a synchronizer chain first. The output register then acts as a level-transparent latch emulated in the clock domain:
- While a load strobe is active, the register takes its source on every clock.
- When the strobe goes inactive, the register keeps the last value it took.

If both strobes are active at once, the parallel path wins. A flag output reports when the latched loop divider lies outside the allowed window.

Top module: `synth_cfg_latch`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs go to `cfg_m` = RESET_M (default 50), `cfg_n` = 0 and `cfg_t` = 0.
- R2: Each rising edge of `ser_clk` shifts `ser_data` into a 12-bit shift register, most significant bit first. A falling edge or a steady level shifts nothing. After 12 shifts the register holds {T[2:0], N[1:0], M[6:0]}, and the last bit shifted in is M[0].
- R3: While `ser_load` is high and `par_load_n` is high, all three outputs follow the shift register. This includes any shifts made while the strobe stays high.
- R4: While both strobes are inactive (`ser_load` low, `par_load_n` high), serial shifting does not change the outputs. The outputs keep the value they had when `ser_load` fell.
- R5: While `par_load_n` is low, `cfg_m` follows `par_m` and `cfg_n` follows `par_n`, and `cfg_t` keeps its value.
- R6: After `par_load_n` rises, changes on `par_m` and `par_n` have no effect on the outputs.
- R7: When both strobes are active, the parallel pins drive `cfg_m` and `cfg_n`, and `cfg_t` keeps its value.
- R8: `m_out_of_range` is high exactly when `cfg_m` < M_LO (20) or `cfg_m` > M_HI (80). Both bounds are inside the valid window.
- R9: Each input passes through SYNC_STAGES flops (default 2). An input change sampled at a clock edge reaches the outputs SYNC_STAGES+1 edges later, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous, idles low |
| ser_data | input | 1 | Serial data, sampled on rising `ser_clk` |
| ser_load | input | 1 | Serial load strobe, active high |
| par_load_n | input | 1 | Parallel load strobe, active low, idles high |
| par_m | input | 7 | Parallel loop divider value |
| par_n | input | 2 | Parallel output divider code (ratio 1, 2, 4, 8) |
| cfg_m | output | 7 | Latched loop divider value |
| cfg_n | output | 2 | Latched output divider code |
| cfg_t | output | 3 | Latched test selector |
| m_out_of_range | output | 1 | Latched loop divider outside M_LO..M_HI |

## Verification
The bench builds the block with its defaults: SYNC_STAGES = 2, RESET_M = 50 and a window of 20 to 80. A two-stage synchronizer puts the R9 latency at exactly three edges, and the bench probes that cycle by cycle. With the window at 20 to 80, the test values 19, 20, 80, 81 and 90 land right on both bounds of the range flag. The reset value of 50 starts inside the window, so the first crossing of the flag is visible.

// File: rtl/cfgl_pkg.sv
// Package: field widths and the packed configuration word shared by the
// shifter, the latch and the top. Assumes T, N, M order from MSB to LSB.
package cfgl_pkg;
    localparam int M_W    = 7;
    localparam int N_W    = 2;
    localparam int T_W    = 3;
    localparam int WORD_W = T_W + N_W + M_W;

    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_word_t;
endpackage

// File: rtl/cfgl_sync.sv
// Module: multi-bit synchronizer chain of STAGES flops into the clk domain.
// Assumes the bits of one bus change only while their strobe is inactive,
// so per-bit skew across the chain is harmless.
module cfgl_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop: capture the raw asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[0] <= RST_VAL;
                else        stage[0] <= d;
            end
        end else begin : g_next
            // Later flops: pass the value one stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[i] <= RST_VAL;
                else        stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/cfgl_shifter.sv
// Module: detects rising edges of the synchronized serial clock and shifts
// serial data in MSB first. Assumes the serial clock is much slower than clk.
module cfgl_shifter
    import cfgl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sclk_s,
    input  logic      sdata_s,
    output cfg_word_t word
);
    logic sclk_prev;
    logic rise;

    assign rise = sclk_s & ~sclk_prev;

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    // Shift one data bit in at each detected rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    word <= '0;
        else if (rise) word <= cfg_word_t'({word[WORD_W-2:0], sdata_s});
    end

    // R2: without a rising edge the shift register does not move.
    a_r2_hold_without_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(word));

    // R2: after a rising edge the new LSB is the sampled data bit.
    a_r2_lsb_is_data: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> word[0] == $past(sdata_s));
endmodule

// File: rtl/cfgl_latch.sv
// Module: emulated transparent latch for the configuration word. Parallel
// strobe (active low) has priority over serial strobe (active high); T is
// written only from the serial word.
module cfgl_latch
    import cfgl_pkg::*;
#(
    parameter int RESET_M = 50
) (
    input  logic           clk,
    input  logic           rst_n,
    input  cfg_word_t      ser_word,
    input  logic           ser_load_s,
    input  logic           par_load_n_s,
    input  logic [M_W-1:0] par_m_s,
    input  logic [N_W-1:0] par_n_s,
    output cfg_word_t      cfg
);
    localparam logic [M_W-1:0] RST_M = M_W'(RESET_M);

    logic par_act;
    logic ser_act;

    assign par_act = ~par_load_n_s;
    assign ser_act = ser_load_s;

    // Follow the active source each clock; hold when no strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.t <= '0;
            cfg.n <= '0;
            cfg.m <= RST_M;
        end else if (par_act) begin
            cfg.m <= par_m_s;
            cfg.n <= par_n_s;
        end else if (ser_act) begin
            cfg <= ser_word;
        end
    end

    // R5: parallel pins reach the latch one edge after being sampled.
    a_r5_par_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        par_act |=> (cfg.m == $past(par_m_s)) && (cfg.n == $past(par_n_s)));

    // R7: the parallel path never disturbs the test selector.
    a_r7_par_keeps_t: assert property (@(posedge clk) disable iff (!rst_n)
        par_act |=> $stable(cfg.t));

    // R3: serial strobe alone copies the whole shift register.
    a_r3_ser_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_act && ser_act) |=> cfg == $past(ser_word));

    // R4 / R6: with no strobe active the configuration holds.
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_act && !ser_act) |=> $stable(cfg));
endmodule

// File: rtl/synth_cfg_latch.sv
// Module: top of the configuration word latch. Synchronizes the serial and
// parallel inputs, shifts the serial word, latches the selected source and
// flags a loop divider outside M_LO..M_HI. Assumes rst_n is synchronous.
module synth_cfg_latch
    import cfgl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RESET_M     = 50,
    parameter int M_LO        = 20,
    parameter int M_HI        = 80
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    input  logic           par_load_n,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    output logic [M_W-1:0] cfg_m,
    output logic [N_W-1:0] cfg_n,
    output logic [T_W-1:0] cfg_t,
    output logic           m_out_of_range
);
    localparam int PAR_W = 1 + M_W + N_W;
    localparam logic [M_W-1:0] LO_M = M_W'(M_LO);
    localparam logic [M_W-1:0] HI_M = M_W'(M_HI);

    logic [2:0]       ser_s;
    logic [PAR_W-1:0] par_s;
    cfg_word_t        ser_word;
    cfg_word_t        cfg;

    cfgl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_ser_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk, ser_data, ser_load}),
        .q     (ser_s)
    );

    cfgl_sync #(.W(PAR_W), .STAGES(SYNC_STAGES),
                .RST_VAL({1'b1, {(M_W + N_W){1'b0}}})) u_par_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({par_load_n, par_m, par_n}),
        .q     (par_s)
    );

    cfgl_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (ser_s[2]),
        .sdata_s (ser_s[1]),
        .word    (ser_word)
    );

    cfgl_latch #(.RESET_M(RESET_M)) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_word     (ser_word),
        .ser_load_s   (ser_s[0]),
        .par_load_n_s (par_s[PAR_W-1]),
        .par_m_s      (par_s[N_W +: M_W]),
        .par_n_s      (par_s[N_W-1:0]),
        .cfg          (cfg)
    );

    assign cfg_m = cfg.m;
    assign cfg_n = cfg.n;
    assign cfg_t = cfg.t;

    // Range flag: loop divider outside the inclusive window.
    always_comb begin
        m_out_of_range = (cfg.m < LO_M) || (cfg.m > HI_M);
    end

    // R1: the cycle after reset the outputs show the reset word.
    a_r1_reset_word: assert property (@(posedge clk)
        !rst_n |=> (cfg_m == M_W'(RESET_M)) && (cfg_n == '0) && (cfg_t == '0));
endmodule

// File: tb/synth_cfg_latch_bench.sv
`timescale 1ns/1ps
module synth_cfg_latch_bench;
    localparam int S       = 2;
    localparam int RESET_M = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic       par_load_n = 1'b1;
    logic [6:0] par_m = 7'd0;
    logic [1:0] par_n = 2'd0;
    logic [6:0] cfg_m;
    logic [1:0] cfg_n;
    logic [2:0] cfg_t;
    logic       m_out_of_range;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    synth_cfg_latch #(.SYNC_STAGES(S), .RESET_M(RESET_M), .M_LO(20), .M_HI(80))
    u_synth_cfg_latch (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .par_load_n(par_load_n), .par_m(par_m),
        .par_n(par_n), .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t),
        .m_out_of_range(m_out_of_range)
    );

    // Reference model: input history queue plus behavioural state.
    // Record layout: [12]sclk [11]sdata [10]sload [9]pload_n [8:2]m [1:0]n
    localparam logic [12:0] IDLE = 13'b0_0_0_1_0000000_00;
    logic [12:0] hist [$];
    logic [11:0] mdl_sh;
    int          mdl_m, mdl_n, mdl_t;

    always @(posedge clk) begin
        logic [12:0] d0, d1;
        logic [11:0] nsh;
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < S + 2; i++) hist.push_back(IDLE);
            mdl_sh = 0; mdl_m = RESET_M; mdl_n = 0; mdl_t = 0;
        end else begin
            hist.push_back({ser_clk, ser_data, ser_load, par_load_n, par_m, par_n});
            void'(hist.pop_front());
            d0 = hist[hist.size() - 1 - S];
            d1 = hist[hist.size() - 2 - S];
            nsh = mdl_sh;
            if (d0[12] && !d1[12]) nsh = {mdl_sh[10:0], d0[11]};
            if (!d0[9]) begin
                mdl_m = int'(d0[8:2]); mdl_n = int'(d0[1:0]);
            end else if (d0[10]) begin
                mdl_t = int'(mdl_sh[11:9]); mdl_n = int'(mdl_sh[8:7]);
                mdl_m = int'(mdl_sh[6:0]);
            end
            mdl_sh = nsh;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model (R9 latency included).
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, "model m", int'(cfg_m), mdl_m);
            chk(cur_req, "model n", int'(cfg_n), mdl_n);
            chk(cur_req, "model t", int'(cfg_t), mdl_t);
            chk("R8", "model flag", int'(m_out_of_range),
                int'(mdl_m < 20 || mdl_m > 80));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [11:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_data = w[i]; ser_clk = 1'b0; tick(4);
            ser_clk = 1'b1; tick(4);
            ser_clk = 1'b0;
        end
        tick(4);
    endtask

    task automatic expect_cfg(input string req, input int m, input int n, input int t);
        chk(req, "cfg_m", int'(cfg_m), m);
        chk(req, "cfg_n", int'(cfg_n), n);
        chk(req, "cfg_t", int'(cfg_t), t);
        chk(req, "flag", int'(m_out_of_range), int'(m < 20 || m > 80));
    endtask

    task automatic finish_up;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog run did not complete actual=1 expected=0");
        finish_up();
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(1);
        expect_cfg("R1", 50, 0, 0);

        // Serial word T=5 N=2 M=33 with strobe low: no effect (R4), then load (R2, R3).
        cur_req = "R4";
        shift_bits(12'b101_10_0100001, 12);
        expect_cfg("R4", 50, 0, 0);
        cur_req = "R3";
        ser_load = 1'b1; tick(6);
        expect_cfg("R2", 33, 2, 5);
        ser_load = 1'b0; tick(6);

        // Shift T=2 N=1 M=90 after the strobe fell: held (R4).
        cur_req = "R4";
        shift_bits(12'b010_01_1011010, 12);
        expect_cfg("R4", 33, 2, 5);

        // Strobe high: transparent, flag for 90 (R3, R8); one more shift while high.
        cur_req = "R3";
        ser_load = 1'b1; tick(6);
        expect_cfg("R3", 90, 1, 2);
        shift_bits(12'b1, 1);
        expect_cfg("R3", 53, 3, 4);
        ser_load = 1'b0; tick(6);

        // Parallel path: track while low, boundary values (R5, R8).
        cur_req = "R5";
        par_m = 7'd19; par_n = 2'd3; tick(2);
        par_load_n = 1'b0; tick(6);
        expect_cfg("R5", 19, 3, 4);
        par_m = 7'd20; par_n = 2'd1; tick(6);
        expect_cfg("R8", 20, 1, 4);
        par_load_n = 1'b1; tick(6);
        cur_req = "R6";
        par_m = 7'd81; par_n = 2'd2; tick(8);
        expect_cfg("R6", 20, 1, 4);

        // Latency: pins at 80, strobe falls; change visible after S+1 edges (R9).
        cur_req = "R9";
        par_m = 7'd80; par_n = 2'd0; tick(4);
        par_load_n = 1'b0;
        tick(S);
        chk("R9", "cfg_m before latency", int'(cfg_m), 20);
        tick(1);
        chk("R9", "cfg_m after latency", int'(cfg_m), 80);
        chk("R8", "flag at 80", int'(m_out_of_range), 0);
        par_m = 7'd81; tick(6);
        chk("R8", "flag at 81", int'(m_out_of_range), 1);
        par_load_n = 1'b1; tick(6);

        // Both strobes: parallel wins, T kept (R7); then serial takes over (R3).
        cur_req = "R7";
        shift_bits(12'b111_00_0001010, 12);
        par_m = 7'd64; par_n = 2'd1; tick(4);
        par_load_n = 1'b0; ser_load = 1'b1; tick(6);
        expect_cfg("R7", 64, 1, 4);
        cur_req = "R3";
        par_load_n = 1'b1; tick(6);
        expect_cfg("R3", 10, 0, 7);
        ser_load = 1'b0; tick(6);

        // Reset again mid-run (R1).
        cur_req = "R1";
        rst_n = 1'b0; tick(2);
        expect_cfg("R1", 50, 0, 0);
        rst_n = 1'b1; tick(4);

        finish_up();
    end
endmodule